// File: doc/BRIEF.md
# Boundary-Splitting Descriptor Table Builder

This block turns a list of memory scatter segments, each an address and a byte length, into a table of fixed-format DMA descriptors written one 32-bit word per cycle into a table memory. A segment that would run across a 64 KiB address boundary is cut into several pieces, so that no descriptor ever spans one. The final descriptor of the list carries an end-of-list flag in its length word.

The table has a fixed capacity derived from the page size: one entry for every 64 bytes of page, which gives 64 entries for a 4 KiB page. A list that needs more entries than that is abandoned. The block still consumes the rest of the list, and then raises an overflow pulse so the caller can fall back to a non-DMA transfer. A list that finishes within capacity produces a done pulse that carries the number of entries. If that number is zero, the caller treats the list as unusable for DMA.

Each segment is offered on a valid/ready stream with a last flag marking the final segment of a list. While the block is turning a segment into descriptors it holds off further segments.

Top module: `desc_table_builder`

## Requirements
- R1: Each descriptor's length is the smaller of the segment bytes still left and 0x10000 minus the low 16 bits of the current address. The address then advances by that length, and the remaining bytes shrink by it, until the segment is used up.
- R2: Entry k occupies table words 4k to 4k+3, in this order: 4k holds zero, 4k+1 holds the address, 4k+2 holds zero, and 4k+3 holds the length word. The length sits in bits 16:0 of the length word. With BIG_ENDIAN=1 (the default), the address and length words are written byte-reversed.
- R3: Bit 31 of the length word, before byte reversal, is set on the final entry of a list and clear on every other entry.
- R4: A list needing exactly MAX_ENTRIES (64 by default) entries completes with done. A list needing one more gives a single-cycle overflow pulse and no done pulse.
- R5: After an overflow is detected part-way through a list, the remaining segments up to and including the one flagged last are accepted and discarded. The next list is then built from entry 0.
- R6: A zero-length segment adds no entry. A list with no entries at all gives done with a count of 0 and makes no table writes.
- R7: done is a single-cycle pulse that carries the entry count on done_count. done and overflow are never high together.
- R8: During and right after reset, seg_ready is high, and tbl_we, done and overflow are low.
- R9: While a segment with a non-zero length is being turned into descriptors, seg_ready is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| seg_valid | input | 1 | A segment is offered |
| seg_ready | output | 1 | The block takes the offered segment at this edge |
| seg_addr | input | ADDR_W | Segment start byte address |
| seg_len | input | LEN_W | Segment length in bytes |
| seg_last | input | 1 | The segment closes the list |
| tbl_we | output | 1 | Table word write strobe |
| tbl_addr | output | log2(4*MAX_ENTRIES) | Table word index |
| tbl_wdata | output | 32 | Table word data |
| done | output | 1 | List finished within capacity |
| done_count | output | log2(MAX_ENTRIES+1) | Entries in the finished table |
| overflow | output | 1 | List needed more entries than the table holds |

## Verification
The stimulus covers several kinds of segment. Some sit wholly inside one 64 KiB window, which checks that no split is made. Others start just below a boundary, which checks that the first piece is cut short. Another starts on a boundary with exactly 64 KiB of length, which checks that a full-window piece has its length in bit 16. There are also lists that mix zero-length segments with splitting ones, which checks that the skipped segment does not disturb numbering or the end-of-list placement. For capacity, an aligned list needing exactly 64 entries is set against an unaligned one needing 65. A second overflow case trips in the middle of a segment that is not the last. The list that follows it must build cleanly from entry 0, which separates a correct drain from a leftover count.

// File: rtl/dtb_pkg.sv
package dtb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHUNK,
    ST_WRITE,
    ST_FINISH,
    ST_DRAIN,
    ST_FAIL
  } build_state_t;

  localparam int unsigned WORD_W = 32;
  localparam int unsigned EOL_BIT = 31;
endpackage

// File: rtl/dtb_chunk_calc.sv
module dtb_chunk_calc #(
  parameter int unsigned LEN_W   = 32,
  parameter int unsigned BOUND_W = 16,
  localparam int unsigned CH_W   = BOUND_W + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [BOUND_W-1:0] addr_lo,
  input  logic [LEN_W-1:0]   remain,
  output logic [CH_W-1:0]    chunk
);
  logic [CH_W-1:0] room;

  always_comb begin
    room = {1'b1, {BOUND_W{1'b0}}} - {1'b0, addr_lo};
    if (remain < LEN_W'(room)) chunk = CH_W'(remain);
    else                        chunk = room;
  end

  // R1: a piece never crosses the window edge and never exceeds what is left
  a_r1_chunk_fits: assert property (@(posedge clk) disable iff (rst)
    (remain != '0) |-> (chunk != '0 && LEN_W'(chunk) <= remain &&
                        ({1'b0, addr_lo} + chunk) <= {1'b1, {BOUND_W{1'b0}}}));
endmodule

// File: rtl/dtb_word_order.sv
module dtb_word_order #(
  parameter bit BIG_ENDIAN = 1'b1
) (
  input  logic [31:0] logical_word,
  output logic [31:0] stored_word
);
  generate
    if (BIG_ENDIAN) begin : g_swap
      for (genvar b = 0; b < 4; b++) begin : g_byte
        assign stored_word[8*b +: 8] = logical_word[8*(3-b) +: 8];
      end
    end else begin : g_pass
      assign stored_word = logical_word;
    end
  endgenerate
endmodule

// File: rtl/desc_table_builder.sv
module desc_table_builder
  import dtb_pkg::*;
#(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned LEN_W      = 32,
  parameter int unsigned PAGE_BYTES = 4096,
  parameter int unsigned BOUND_W    = 16,
  parameter bit          BIG_ENDIAN = 1'b1,
  localparam int unsigned MAX_ENTRIES = PAGE_BYTES / 64,
  localparam int unsigned IDX_W   = $clog2(MAX_ENTRIES),
  localparam int unsigned TADDR_W = IDX_W + 2,
  localparam int unsigned CNT_W   = $clog2(MAX_ENTRIES + 1),
  localparam int unsigned CH_W    = BOUND_W + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               seg_valid,
  output logic               seg_ready,
  input  logic [ADDR_W-1:0]  seg_addr,
  input  logic [LEN_W-1:0]   seg_len,
  input  logic               seg_last,
  output logic               tbl_we,
  output logic [TADDR_W-1:0] tbl_addr,
  output logic [31:0]        tbl_wdata,
  output logic               done,
  output logic [CNT_W-1:0]   done_count,
  output logic               overflow
);
  localparam int unsigned PAD_W = EOL_BIT - CH_W;

  build_state_t      state;
  logic [ADDR_W-1:0] cur_addr, ch_addr;
  logic [LEN_W-1:0]  remain;
  logic              cur_last;
  logic [CH_W-1:0]   chunk, ch_len, pend_len;
  logic [IDX_W-1:0]  pend_idx;
  logic              pend_v;
  logic [CNT_W-1:0]  cnt;
  logic [1:0]        wstep;
  logic              accept;
  logic [31:0]       addr_logic, addr_stored, len_logic, len_stored;

  assign seg_ready = (state == ST_IDLE) || (state == ST_DRAIN);
  assign accept    = seg_valid && seg_ready;

  dtb_chunk_calc #(.LEN_W(LEN_W), .BOUND_W(BOUND_W)) u_chunk (
    .clk(clk), .rst(rst), .addr_lo(cur_addr[BOUND_W-1:0]),
    .remain(remain), .chunk(chunk)
  );

  always_comb begin
    addr_logic = '0;
    addr_logic[ADDR_W-1:0] = ch_addr;
    len_logic = {(state == ST_FINISH), {PAD_W{1'b0}}, pend_len};
  end

  dtb_word_order #(.BIG_ENDIAN(BIG_ENDIAN)) u_addr_order (
    .logical_word(addr_logic), .stored_word(addr_stored));
  dtb_word_order #(.BIG_ENDIAN(BIG_ENDIAN)) u_len_order (
    .logical_word(len_logic), .stored_word(len_stored));

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      cur_addr   <= '0;
      ch_addr    <= '0;
      remain     <= '0;
      cur_last   <= 1'b0;
      ch_len     <= '0;
      pend_len   <= '0;
      pend_idx   <= '0;
      pend_v     <= 1'b0;
      cnt        <= '0;
      wstep      <= '0;
      tbl_we     <= 1'b0;
      tbl_addr   <= '0;
      tbl_wdata  <= '0;
      done       <= 1'b0;
      done_count <= '0;
      overflow   <= 1'b0;
    end else begin
      tbl_we   <= 1'b0;
      done     <= 1'b0;
      overflow <= 1'b0;
      unique case (state)
        ST_IDLE: if (accept) begin
          if (seg_len == '0) begin
            if (seg_last) state <= ST_FINISH;
          end else begin
            cur_addr <= seg_addr;
            remain   <= seg_len;
            cur_last <= seg_last;
            state    <= ST_CHUNK;
          end
        end
        ST_CHUNK: begin
          if (cnt == CNT_W'(MAX_ENTRIES)) begin
            state <= cur_last ? ST_FAIL : ST_DRAIN;
          end else begin
            ch_addr  <= cur_addr;
            ch_len   <= chunk;
            cur_addr <= cur_addr + ADDR_W'(chunk);
            remain   <= remain - LEN_W'(chunk);
            wstep    <= 2'd0;
            state    <= ST_WRITE;
          end
        end
        ST_WRITE: begin
          wstep <= wstep + 2'd1;
          unique case (wstep)
            2'd0: if (pend_v) begin
              tbl_we    <= 1'b1;
              tbl_addr  <= {pend_idx, 2'd3};
              tbl_wdata <= len_stored;
            end
            2'd1: begin
              tbl_we    <= 1'b1;
              tbl_addr  <= {cnt[IDX_W-1:0], 2'd0};
              tbl_wdata <= '0;
            end
            2'd2: begin
              tbl_we    <= 1'b1;
              tbl_addr  <= {cnt[IDX_W-1:0], 2'd1};
              tbl_wdata <= addr_stored;
            end
            default: begin
              tbl_we    <= 1'b1;
              tbl_addr  <= {cnt[IDX_W-1:0], 2'd2};
              tbl_wdata <= '0;
              pend_len  <= ch_len;
              pend_idx  <= cnt[IDX_W-1:0];
              pend_v    <= 1'b1;
              cnt       <= cnt + 1'b1;
              if (remain != '0)  state <= ST_CHUNK;
              else if (cur_last) state <= ST_FINISH;
              else               state <= ST_IDLE;
            end
          endcase
        end
        ST_FINISH: begin
          if (pend_v) begin
            tbl_we    <= 1'b1;
            tbl_addr  <= {pend_idx, 2'd3};
            tbl_wdata <= len_stored;
          end
          done       <= 1'b1;
          done_count <= cnt;
          pend_v     <= 1'b0;
          cnt        <= '0;
          state      <= ST_IDLE;
        end
        ST_DRAIN: if (accept && seg_last) state <= ST_FAIL;
        default: begin
          overflow <= 1'b1;
          pend_v   <= 1'b0;
          cnt      <= '0;
          state    <= ST_IDLE;
        end
      endcase
    end
  end

  // R7: outcome pulses are exclusive and one cycle wide
  a_r7_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(done && overflow));
  a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R4: overflow is a single pulse; a finished table never exceeds capacity
  a_r4_ovf_single: assert property (@(posedge clk) disable iff (rst)
    overflow |=> !overflow);
  a_r4_count_cap: assert property (@(posedge clk) disable iff (rst)
    done |-> (done_count <= CNT_W'(MAX_ENTRIES)));
  // R3: a non-empty table finishes with its end-of-list length write
  a_r3_eol_with_done: assert property (@(posedge clk) disable iff (rst)
    (done && done_count != '0) |-> (tbl_we && tbl_addr[1:0] == 2'd3));
endmodule

// File: tb/desc_table_builder_tb.sv
module desc_table_builder_tb_top;
  localparam int MAXE = 64;
  localparam int NV   = 9;

  // per vector: segment count, up to three (addr, len) pairs
  localparam int          V_NS [0:NV-1] = '{1, 1, 1, 3, 2, 1, 1, 2, 1};
  localparam logic [31:0] V_A  [0:NV-1][0:2] = '{
    '{32'h0000_1000, 0, 0}, '{32'h0000_FF00, 0, 0}, '{32'h0002_0000, 0, 0},
    '{32'h0001_FFF0, 32'h0000_5000, 32'h0003_0000}, '{0, 0, 0},
    '{32'h0000_0000, 0, 0}, '{32'h0000_8000, 0, 0},
    '{32'h0000_0000, 32'h0000_0100, 0}, '{32'h0000_FF00, 0, 0}};
  localparam logic [31:0] V_L  [0:NV-1][0:2] = '{
    '{32'h200, 0, 0}, '{32'h300, 0, 0}, '{32'h1_0000, 0, 0},
    '{32'h20, 32'h0, 32'h1_8000}, '{0, 0, 0},
    '{32'h40_0000, 0, 0}, '{32'h40_0000, 0, 0},
    '{32'h41_0000, 32'h10, 0}, '{32'h300, 0, 0}};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic seg_valid = 1'b0, seg_last = 1'b0;
  logic [31:0] seg_addr = '0, seg_len = '0;
  logic seg_ready, tbl_we, done, overflow;
  logic [7:0] tbl_addr;
  logic [31:0] tbl_wdata;
  logic [6:0] done_count;

  always #5 clk = ~clk;

  desc_table_builder dut_i (
    .clk(clk), .rst(rst), .seg_valid(seg_valid), .seg_ready(seg_ready),
    .seg_addr(seg_addr), .seg_len(seg_len), .seg_last(seg_last),
    .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_wdata(tbl_wdata),
    .done(done), .done_count(done_count), .overflow(overflow));

  int checks = 0, errors = 0;
  int wr_cnt = 0, done_pulses = 0, ovf_pulses = 0, cycles = 0;
  logic [6:0] last_count = '0;
  logic [31:0] mirror [0:4*MAXE-1];
  logic [31:0] exp_a [0:MAXE-1];
  logic [31:0] exp_l [0:MAXE-1];

  always @(negedge clk) begin
    cycles++;
    if (tbl_we) begin mirror[tbl_addr] = tbl_wdata; wr_cnt++; end
    if (done) begin done_pulses++; last_count = done_count; end
    if (overflow) ovf_pulses++;
    if (cycles > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual %0d cycles expected < 150000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic logic [31:0] bswap(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic model(input int v, output int n, output bit ovf);
    n = 0; ovf = 0;
    for (int s = 0; s < V_NS[v]; s++) begin
      logic [31:0] a, rem, room, c;
      a = V_A[v][s]; rem = V_L[v][s];
      while (rem != 0 && !ovf) begin
        room = 32'h1_0000 - {16'h0, a[15:0]};
        c = (rem < room) ? rem : room;
        if (n >= MAXE) ovf = 1;
        else begin exp_a[n] = a; exp_l[n] = c; n++; end
        a += c; rem -= c;
      end
    end
  endtask

  task automatic send_seg(input logic [31:0] a, input logic [31:0] l,
                          input logic last);
    seg_addr = a; seg_len = l; seg_last = last; seg_valid = 1'b1;
    while (!seg_ready) @(negedge clk);
    @(negedge clk);
    seg_valid = 1'b0; seg_last = 1'b0;
  endtask

  task automatic wait_outcome(input int d0, input int o0);
    int lim = 0;
    while (done_pulses == d0 && ovf_pulses == o0 && lim < 3000) begin
      @(negedge clk); lim++;
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    // R8: state during and right after reset
    repeat (3) @(negedge clk);
    chk(seg_ready === 1'b1, "R8", "ready in reset", {31'b0, seg_ready}, 1);
    chk(tbl_we === 1'b0 && done === 1'b0 && overflow === 1'b0, "R8",
        "we/done/ovf in reset", {29'b0, tbl_we, done, overflow}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(seg_ready === 1'b1 && done === 1'b0 && wr_cnt == 0, "R8",
        "idle after reset", wr_cnt, 0);

    for (int v = 0; v < NV; v++) begin
      int n, d0, o0, w0;
      bit ovf;
      model(v, n, ovf);
      d0 = done_pulses; o0 = ovf_pulses; w0 = wr_cnt;
      for (int s = 0; s < V_NS[v]; s++)
        send_seg(V_A[v][s], V_L[v][s], s == V_NS[v] - 1);
      wait_outcome(d0, o0);
      if (ovf) begin
        chk(ovf_pulses - o0 == 1, "R4", $sformatf("vec %0d overflow pulses", v),
            ovf_pulses - o0, 1);
        chk(done_pulses == d0, "R5", $sformatf("vec %0d no done", v),
            done_pulses - d0, 0);
      end else begin
        chk(done_pulses - d0 == 1 && ovf_pulses == o0, "R7",
            $sformatf("vec %0d one done pulse", v), done_pulses - d0, 1);
        chk(last_count == 7'(n), "R7", $sformatf("vec %0d count", v),
            {25'b0, last_count}, n);
        chk(wr_cnt - w0 == 4 * n, "R6", $sformatf("vec %0d write count", v),
            wr_cnt - w0, 4 * n);
        for (int e = 0; e < n; e++) begin
          logic [31:0] el;
          el = exp_l[e] | ((e == n - 1) ? 32'h8000_0000 : 32'h0);
          chk(mirror[4*e] === 0 && mirror[4*e+2] === 0, "R2",
              $sformatf("vec %0d entry %0d zero words", v, e),
              mirror[4*e] | mirror[4*e+2], 0);
          chk(mirror[4*e+1] === bswap(exp_a[e]), "R1",
              $sformatf("vec %0d entry %0d addr", v, e),
              mirror[4*e+1], bswap(exp_a[e]));
          chk(mirror[4*e+3] === bswap(el), "R3",
              $sformatf("vec %0d entry %0d len/eol", v, e),
              mirror[4*e+3], bswap(el));
        end
      end
    end

    // R9: busy while splitting a segment
    begin
      int d0, o0;
      d0 = done_pulses; o0 = ovf_pulses;
      send_seg(32'h0000_0040, 32'h10, 1'b1);
      chk(seg_ready === 1'b0, "R9", "ready low while building",
          {31'b0, seg_ready}, 0);
      wait_outcome(d0, o0);
      chk(done === 1'b0 && done_pulses - d0 == 1, "R7", "done single pulse",
          done_pulses - d0, 1);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule